// File: doc/BRIEF.md
# Dual-Path Latched/Registered Bus Transceiver

This block connects two 18-bit buses, A and B, with one storage path for each direction. Data from bus A reaches bus B through the A-to-B path, and data from bus B reaches bus A through the B-to-A path. Each path is built from one storage element with three behaviours. It can follow its input (transparent), keep its stored word, or load a new word on a rising edge of its own capture strobe. A capture-enable qualifies that strobe. An active-low output enable places the path's bus output in a driving state or in a released, high-impedance state.

Every pin is modelled inside one synchronous core clock domain. Each bus pad has a data input, a per-bit "externally driven" flag, a data output and an output-enable flag. The high-impedance state appears as a deasserted output-enable flag with the data forced to zero. A bus-hold stage at each input keeps, bit by bit, the last value that an outside driver put on the pad. A bit that nobody drives therefore never floats. The capture strobes are sampled by the core clock, and a path loads on the first core edge at which its strobe is seen high after having been seen low.

The surrounding system must never enable both directions' outputs at the same time.

Top module: `dual_path_xcvr`

## Requirements
- R1: After reset every stored word and every bus-hold value is zero, so an enabled path that is neither following nor capturing drives 0.
- R2: While `ab_le` is 1 and `ab_oe_n` is 0, `b_pad_o` equals the resolved A bus value in the same cycle, with no clock edge in between.
- R3: While `ab_le` is 0 and no capture occurs, `b_pad_o` keeps the stored word whatever bus A does.
- R4: With `ab_le` 0 and `ab_cken_n` 0, a core clock edge that sees `ab_clk` at 1, after the previous edge saw it at 0, loads the resolved A value. The new word appears on `b_pad_o` after that edge.
- R5: With `ab_cken_n` at 1, a rising capture strobe leaves the stored word unchanged.
- R6: `ab_le` at 1 takes priority over the strobe, and storage tracks the input on every core edge. When `ab_le` returns to 0, the path keeps the value it sampled at the last core edge that saw `ab_le` at 1.
- R7: While an output enable is 1, the matching output-enable flag (`b_oe_o` or `a_oe_o`) is 0 and the data output is 0. Storage keeps operating, and a word captured while the output is disabled appears once the output is enabled again.
- R8: The B-to-A path behaves the same way, using `ba_oe_n`, `ba_le`, `ba_clk` and `ba_cken_n`, and it is independent of the A-to-B controls. `ab_oe_n` and `ba_oe_n` are never both 0.
- R9: A pad bit whose drive flag is 0 resolves to the last value seen on that bit at a core edge while its flag was 1. A bit whose flag is 1 resolves to its pad input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; samples strobes and updates storage |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_pad_i | input | 18 | Value present on bus A from outside |
| a_drv_i | input | 18 | Per-bit flag: bus A bit is driven from outside |
| a_pad_o | output | 18 | Value the B-to-A path drives onto bus A |
| a_oe_o | output | 1 | 1 when the B-to-A path drives bus A |
| b_pad_i | input | 18 | Value present on bus B from outside |
| b_drv_i | input | 18 | Per-bit flag: bus B bit is driven from outside |
| b_pad_o | output | 18 | Value the A-to-B path drives onto bus B |
| b_oe_o | output | 1 | 1 when the A-to-B path drives bus B |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B transparent enable |
| ab_clk | input | 1 | A-to-B capture strobe |
| ab_cken_n | input | 1 | A-to-B capture enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A transparent enable |
| ba_clk | input | 1 | B-to-A capture strobe |
| ba_cken_n | input | 1 | B-to-A capture enable, active low |

## Verification
Four properties are checked on every cycle. The released-output encoding is checked for both paths. The transparent path equals the input whenever all bits are driven. An enabled, non-transparent output stays steady when the strobe was low or the capture enable was off. The two output enables are never active together. Other behaviours need a sequence of stimulus, so only the bench scenarios show them: the actual loading of a word on a strobe edge, the value kept when transparency closes, capture while the output is released, and the per-bit bus-hold memory.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    parameter int XCVR_W = 18;

    typedef enum logic [1:0] {
        PM_HOLD    = 2'd0,
        PM_FOLLOW  = 2'd1,
        PM_CAPTURE = 2'd2
    } path_mode_e;

    // Transparency outranks the strobe; the strobe only counts when enabled.
    function automatic path_mode_e pick_mode(input logic le, input logic rise, input logic en_n);
        if (le)
            return PM_FOLLOW;
        else if (rise && !en_n)
            return PM_CAPTURE;
        else
            return PM_HOLD;
    endfunction

endpackage

// File: rtl/xcvr_bus_hold.sv
module xcvr_bus_hold
    import xcvr_pkg::*;
#(
    parameter int W = XCVR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_i,
    input  logic [W-1:0] drv_i,
    output logic [W-1:0] line_o
);

    logic [W-1:0] hold_d, hold_q;

    // One identical keeper per bit
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            hold_d[i] = drv_i[i] ? pad_i[i] : hold_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hold_q <= '0;
        else
            hold_q <= hold_d;
    end

    assign line_o = hold_d;

endmodule

// File: rtl/xcvr_dir_path.sv
module xcvr_dir_path
    import xcvr_pkg::*;
#(
    parameter int W = XCVR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    input  logic         le_i,
    input  logic         cap_clk_i,
    input  logic         cap_en_n_i,
    input  logic         oe_n_i,
    output logic [W-1:0] q_o,
    output logic         oe_o
);

    typedef struct packed {
        logic [W-1:0] store;
        logic         strobe_prev;
    } path_st_t;

    path_st_t   st_d, st_q;
    path_mode_e mode;
    logic       rise;
    logic [W-1:0] view;

    always_comb begin
        rise            = cap_clk_i & ~st_q.strobe_prev;
        mode            = pick_mode(le_i, rise, cap_en_n_i);
        st_d            = st_q;
        st_d.strobe_prev = cap_clk_i;
        case (mode)
            PM_FOLLOW, PM_CAPTURE: st_d.store = d_i;
            default:               st_d.store = st_q.store;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // Transparent view bypasses storage so it follows within the cycle
    assign view = le_i ? d_i : st_q.store;
    assign oe_o = ~oe_n_i;
    assign q_o  = oe_o ? view : '0;

endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr
    import xcvr_pkg::*;
#(
    parameter int W = XCVR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_pad_i,
    input  logic [W-1:0] a_drv_i,
    output logic [W-1:0] a_pad_o,
    output logic         a_oe_o,
    input  logic [W-1:0] b_pad_i,
    input  logic [W-1:0] b_drv_i,
    output logic [W-1:0] b_pad_o,
    output logic         b_oe_o,
    input  logic         ab_oe_n,
    input  logic         ab_le,
    input  logic         ab_clk,
    input  logic         ab_cken_n,
    input  logic         ba_oe_n,
    input  logic         ba_le,
    input  logic         ba_clk,
    input  logic         ba_cken_n
);

    logic [W-1:0] a_line, b_line;

    xcvr_bus_hold #(.W(W)) u_hold_a (
        .clk   (clk),
        .rst_n (rst_n),
        .pad_i (a_pad_i),
        .drv_i (a_drv_i),
        .line_o(a_line)
    );

    xcvr_bus_hold #(.W(W)) u_hold_b (
        .clk   (clk),
        .rst_n (rst_n),
        .pad_i (b_pad_i),
        .drv_i (b_drv_i),
        .line_o(b_line)
    );

    xcvr_dir_path #(.W(W)) u_path_ab (
        .clk       (clk),
        .rst_n     (rst_n),
        .d_i       (a_line),
        .le_i      (ab_le),
        .cap_clk_i (ab_clk),
        .cap_en_n_i(ab_cken_n),
        .oe_n_i    (ab_oe_n),
        .q_o       (b_pad_o),
        .oe_o      (b_oe_o)
    );

    xcvr_dir_path #(.W(W)) u_path_ba (
        .clk       (clk),
        .rst_n     (rst_n),
        .d_i       (b_line),
        .le_i      (ba_le),
        .cap_clk_i (ba_clk),
        .cap_en_n_i(ba_cken_n),
        .oe_n_i    (ba_oe_n),
        .q_o       (a_pad_o),
        .oe_o      (a_oe_o)
    );

endmodule

// File: rtl/dual_path_xcvr_chk.sv
module dual_path_xcvr_chk #(
    parameter int W = 18
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_pad_i,
    input logic [W-1:0] a_drv_i,
    input logic [W-1:0] b_pad_i,
    input logic [W-1:0] b_drv_i,
    input logic [W-1:0] a_pad_o,
    input logic         a_oe_o,
    input logic [W-1:0] b_pad_o,
    input logic         b_oe_o,
    input logic         ab_oe_n,
    input logic         ab_le,
    input logic         ab_clk,
    input logic         ab_cken_n,
    input logic         ba_oe_n,
    input logic         ba_le,
    input logic         ba_clk
);

    // R7: released output reads as flag low, data zero
    a_r7_release_ab: assert property (@(posedge clk) disable iff (!rst_n)
        ab_oe_n |-> (!b_oe_o && b_pad_o == '0));
    a_r7_release_ba: assert property (@(posedge clk) disable iff (!rst_n)
        ba_oe_n |-> (!a_oe_o && a_pad_o == '0));

    // R2: transparent path shows the driven input directly
    a_r2_follow_ab: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_le && !ab_oe_n && (&a_drv_i)) |-> (b_pad_o == a_pad_i));
    // R8: mirror direction
    a_r8_follow_ba: assert property (@(posedge clk) disable iff (!rst_n)
        (ba_le && !ba_oe_n && (&b_drv_i)) |-> (a_pad_o == b_pad_i));

    // R3: no strobe seen high at the previous edge, so no load
    a_r3_keep_ab: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && !$past(ab_le) && !$past(ab_clk) && !ab_oe_n && !$past(ab_oe_n))
        |-> $stable(b_pad_o));
    // R5: capture enable off at the previous edge, so no load
    a_r5_gate_ab: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && !$past(ab_le) && $past(ab_cken_n) && !ab_oe_n && !$past(ab_oe_n))
        |-> $stable(b_pad_o));
    // R8: mirror keep
    a_r8_keep_ba: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_le && !$past(ba_le) && !$past(ba_clk) && !ba_oe_n && !$past(ba_oe_n))
        |-> $stable(a_pad_o));

    // R8: both directions never drive together
    a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ab_oe_n && !ba_oe_n));

endmodule

bind dual_path_xcvr dual_path_xcvr_chk #(.W(W)) u_chk (.*);

// File: tb/test_dual_path_xcvr.sv
`timescale 1ns/1ps
module test_dual_path_xcvr;

    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_pad_i = '0, a_drv_i = '1, b_pad_i = '0, b_drv_i = '1;
    logic [W-1:0] a_pad_o, b_pad_o;
    logic         a_oe_o, b_oe_o;
    logic         ab_oe_n = 1'b1, ab_le = 1'b0, ab_clk = 1'b0, ab_cken_n = 1'b1;
    logic         ba_oe_n = 1'b1, ba_le = 1'b0, ba_clk = 1'b0, ba_cken_n = 1'b1;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    typedef struct {
        bit           on_b;
        logic [W-1:0] val;
        logic         oe;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    event chk_ev;

    always #5 clk = ~clk;

    dual_path_xcvr #(.W(W)) i_dual_path_xcvr (
        .clk(clk), .rst_n(rst_n),
        .a_pad_i(a_pad_i), .a_drv_i(a_drv_i), .a_pad_o(a_pad_o), .a_oe_o(a_oe_o),
        .b_pad_i(b_pad_i), .b_drv_i(b_drv_i), .b_pad_o(b_pad_o), .b_oe_o(b_oe_o),
        .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_clk(ab_clk), .ab_cken_n(ab_cken_n),
        .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_clk(ba_clk), .ba_cken_n(ba_cken_n)
    );

    // Driver side: queue an expectation and wake the monitor
    task automatic expect_bus(input bit on_b, input logic [W-1:0] val,
                              input logic oe, input string tag);
        exp_t e;
        e.on_b = on_b; e.val = val; e.oe = oe; e.tag = tag;
        exp_q.push_back(e);
        -> chk_ev;
        #0.1;
    endtask

    // Monitor: pop and compare against the bus it names
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                logic [W-1:0] got_v;
                logic         got_oe;
                e = exp_q.pop_front();
                got_v  = e.on_b ? b_pad_o : a_pad_o;
                got_oe = e.on_b ? b_oe_o  : a_oe_o;
                n_checks++;
                if (got_v !== e.val || got_oe !== e.oe) begin
                    n_errors++;
                    $display("FAIL %s: got data=%05h oe=%0b, expected data=%05h oe=%0b",
                             e.tag, got_v, got_oe, e.val, e.oe);
                end
            end
        end
    end

    task automatic at_neg();
        @(negedge clk);
        #1;
    endtask

    task automatic past_edge();
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset contents and released defaults
        at_neg();
        expect_bus(1'b1, '0, 1'b0, "R7 B released at start");
        expect_bus(1'b0, '0, 1'b0, "R7 A released at start");
        ab_oe_n = 1'b0;
        #1 expect_bus(1'b1, '0, 1'b1, "R1 stored word zero after reset");

        // R2: transparent follow within the cycle
        at_neg();
        ab_le = 1'b1; a_pad_i = 18'h2A5A5;
        #1 expect_bus(1'b1, 18'h2A5A5, 1'b1, "R2 follow first pattern");
        a_pad_i = 18'h15A5A;
        #1 expect_bus(1'b1, 18'h15A5A, 1'b1, "R2 follow second pattern");

        // R6: strobe while transparent, then close
        at_neg();
        a_pad_i = 18'h3C3C3; ab_cken_n = 1'b0; ab_clk = 1'b1;
        past_edge();
        expect_bus(1'b1, 18'h3C3C3, 1'b1, "R6 strobe adds nothing while transparent");
        at_neg();
        ab_le = 1'b0; ab_clk = 1'b0; ab_cken_n = 1'b1;
        #1 expect_bus(1'b1, 18'h3C3C3, 1'b1, "R6 closed keeps last sampled word");

        // R3: hold regardless of bus A
        at_neg();
        a_pad_i = 18'h00FFF;
        repeat (3) past_edge();
        expect_bus(1'b1, 18'h3C3C3, 1'b1, "R3 hold while A changes");

        // R4: enabled capture on strobe rise
        at_neg();
        ab_cken_n = 1'b0; ab_clk = 1'b1;
        #1 expect_bus(1'b1, 18'h3C3C3, 1'b1, "R4 no load before core edge");
        past_edge();
        expect_bus(1'b1, 18'h00FFF, 1'b1, "R4 load after core edge");
        at_neg();
        ab_clk = 1'b0;
        a_pad_i = 18'h12345;
        past_edge();
        expect_bus(1'b1, 18'h00FFF, 1'b1, "R3 strobe falling does not load");

        // R5: capture disabled
        at_neg();
        ab_cken_n = 1'b1; ab_clk = 1'b1;
        past_edge();
        past_edge();
        expect_bus(1'b1, 18'h00FFF, 1'b1, "R5 strobe ignored with enable off");
        at_neg();
        ab_clk = 1'b0;
        past_edge();

        // R7: release, capture while released, re-enable
        at_neg();
        ab_oe_n = 1'b1;
        #1 expect_bus(1'b1, '0, 1'b0, "R7 released output");
        a_pad_i = 18'h20001; ab_cken_n = 1'b0; ab_clk = 1'b1;
        past_edge();
        at_neg();
        ab_clk = 1'b0; ab_cken_n = 1'b1; ab_oe_n = 1'b0;
        #1 expect_bus(1'b1, 18'h20001, 1'b1, "R7 word captured while released");

        // R9: bus hold per bit
        at_neg();
        ab_le = 1'b1; a_drv_i = '1; a_pad_i = 18'h3FFF0;
        past_edge();
        at_neg();
        a_drv_i = 18'h3FFF0; a_pad_i = 18'h0000F;
        #1 expect_bus(1'b1, 18'h00000, 1'b1, "R9 undriven bits keep zero");
        at_neg();
        a_drv_i = '1; a_pad_i = 18'h0000F;
        past_edge();
        at_neg();
        a_drv_i = 18'h3FFF0; a_pad_i = 18'h00000;
        #1 expect_bus(1'b1, 18'h0000F, 1'b1, "R9 undriven bits keep ones");
        past_edge();
        expect_bus(1'b1, 18'h0000F, 1'b1, "R9 hold persists over edges");

        // R8: B-to-A direction
        at_neg();
        ab_le = 1'b0; a_drv_i = '1; ab_oe_n = 1'b1;
        ba_oe_n = 1'b0; ba_le = 1'b1; b_pad_i = 18'h1BEEF;
        #1 expect_bus(1'b0, 18'h1BEEF, 1'b1, "R8 B-to-A follow");
        expect_bus(1'b1, '0, 1'b0, "R8 A-to-B released independently");
        past_edge();
        at_neg();
        ba_le = 1'b0; b_pad_i = 18'h00ABC;
        #1 expect_bus(1'b0, 18'h1BEEF, 1'b1, "R8 B-to-A hold");
        ba_cken_n = 1'b0; ba_clk = 1'b1;
        past_edge();
        expect_bus(1'b0, 18'h00ABC, 1'b1, "R8 B-to-A capture");
        at_neg();
        ba_clk = 1'b0;
        past_edge();

        #1;
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule